// File: doc/BRIEF.md
# Serial ADC Frame-Aligned Deserializer

This block turns one serial data lane from a 12-bit converter into parallel sample words. The lane runs at twice the bit-clock rate: one bit is presented around each rising edge of the source-synchronous bit clock and one around each falling edge. A 240 MHz bit clock therefore gives 480 Mbit/s, and a word arrives every six bit-clock cycles, which is 40 MS/s. A frame clock travels with the data. Its rising edge marks the bit-clock cycle that carries the most significant bit of a sample, so word boundaries come from the frame clock and not from a free-running bit count.

The block checks that frame edges keep arriving exactly one word apart. It raises a locked flag once the spacing has held for three edges in a row. It drops that flag as soon as an edge comes early or fails to come. Completed words leave on a parallel output with a one-cycle valid strobe in the bit-clock domain, and the strobe is withheld while the flag is low. The output stream has no ready input. The lane cannot be stalled, so a consumer must accept every word in the cycle its valid is high.

Top module: `sadc_deser`

## Requirements
- R1: While `rst_i` is high and after it is released with no traffic, `word_o` is 0 and `valid_o` and `locked_o` are 0.
- R2: Bits enter MSB first. In each bit-clock cycle the bit sampled on the rising edge comes before the bit sampled on the falling edge. The rising-edge bit of the first cycle becomes `word_o[11]` and the falling-edge bit of the sixth cycle becomes `word_o[0]`.
- R3: A frame edge is a rising-clock sample of `frame_i` at 1 after a sample at 0. The cycle in which that sample is taken is the first of a six-cycle word.
- R4: `word_o` and `valid_o` update on the rising edge that follows the falling edge carrying a word's last bit. `valid_o` is high for exactly that one cycle.
- R5: The first frame edge after reset, or after lock is lost, is a reference. `locked_o` rises when the third further edge arrives, provided each edge comes exactly six cycles after the previous one. The flag changes on the rising edge after the one that sampled the frame edge.
- R6: A frame edge that arrives before six cycles have passed since the previous edge drops `locked_o` with the same latency. The partial word is discarded and that edge becomes the new reference.
- R7: If six cycles pass after a word start without a frame edge, `locked_o` drops with the same latency. Lane bits are ignored until the next edge, which becomes a reference.
- R8: A word that completes while `locked_o` is low produces no `valid_o` pulse.
- R9: `valid_o` is never high outside the single cycle named in R4, so two pulses are always at least six cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source-synchronous bit clock; lane sampled on both edges |
| rst_i | input | 1 | Synchronous active-high reset |
| ser_i | input | 1 | Serial lane data, already converted to single-ended |
| frame_i | input | 1 | Frame clock, high for the first half of each word |
| word_o | output | 12 | Last completed sample word |
| valid_o | output | 1 | One-cycle strobe for a new word on `word_o` |
| locked_o | output | 1 | Frame spacing has been confirmed |

## Verification
A word's result is due one rising edge after the rising edge that captured its sixth rising-edge bit. The bench records that edge number when it drives the last pair. A monitor running on falling clock edges then expects `valid_o` and the matching word in exactly that cycle, and treats a strobe in any other cycle as an error. A lock change is due one rising edge after the rising edge that samples the frame edge, so the bench reads `locked_o` two nanoseconds after the second rising edge of each word. All 4096 sample values are swept under lock. Short words of four and five pairs and a word without any frame edge then exercise loss of lock and recovery.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  // Two lane bits gathered in one bit-clock cycle.
  typedef struct packed {
    logic early; // sampled on the rising edge
    logic late;  // sampled on the following falling edge
  } bit_pair_t;
endpackage

// File: rtl/sadc_ddr_capture.sv
module sadc_ddr_capture
  import sadc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      ser_i,
  input  logic      frame_i,
  output bit_pair_t pair_o,
  output logic      frame_edge_o
);
  logic early_q;
  logic late_q;
  logic frm_q;
  logic frm_qq;

  // Rising-edge bit and frame level share one pipeline stage.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      early_q <= 1'b0;
      frm_q   <= 1'b0;
      frm_qq  <= 1'b0;
    end else begin
      early_q <= ser_i;
      frm_q   <= frame_i;
      frm_qq  <= frm_q;
    end
  end

  // Falling-edge bit, held until the next rising edge consumes it.
  always_ff @(negedge clk_i) begin
    if (rst_i) late_q <= 1'b0;
    else       late_q <= ser_i;
  end

  assign pair_o.early  = early_q;
  assign pair_o.late   = late_q;
  assign frame_edge_o  = frm_q & ~frm_qq;
endmodule

// File: rtl/sadc_frame_tracker.sv
module sadc_frame_tracker #(
  parameter int PAIRS      = 6,
  parameter int LOCK_EDGES = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic edge_i,
  output logic restart_o,
  output logic shift_o,
  output logic done_o,
  output logic locked_o
);
  localparam int CW = $clog2(PAIRS + 1);
  localparam int GW = $clog2(LOCK_EDGES + 1);
  localparam logic [CW-1:0] FULL = CW'(PAIRS);
  localparam logic [CW-1:0] LAST = CW'(PAIRS - 1);
  localparam logic [GW-1:0] GOAL = GW'(LOCK_EDGES);

  logic [CW-1:0] cnt_q;   // pairs collected in current word, 0 = hunting
  logic [GW-1:0] good_q;  // consecutive well-spaced edges
  logic          locked_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      good_q   <= '0;
      locked_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q <= CW'(1);
      if (cnt_q == FULL) begin
        if (good_q != GOAL) good_q <= good_q + GW'(1);
        if (good_q + GW'(1) >= GOAL) locked_q <= 1'b1;
      end else begin
        good_q   <= '0;
        locked_q <= 1'b0;
      end
    end else if (cnt_q == FULL) begin
      cnt_q    <= '0;
      good_q   <= '0;
      locked_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign restart_o = edge_i;
  assign shift_o   = !edge_i && (cnt_q != '0) && (cnt_q != FULL);
  assign done_o    = shift_o && (cnt_q == LAST);
  assign locked_o  = locked_q;

  p_cnt_bounded_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= FULL);

  p_lock_after_spacing_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(locked_q) |-> ($past(edge_i) && $past(cnt_q) == FULL));

  p_misplaced_unlocks_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (edge_i && cnt_q != '0 && cnt_q != FULL) |=> (!locked_q && cnt_q == CW'(1)));

  p_missing_unlocks_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!edge_i && cnt_q == FULL) |=> (!locked_q && cnt_q == '0));
endmodule

// File: rtl/sadc_word_assembler.sv
module sadc_word_assembler
  import sadc_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  bit_pair_t         pair_i,
  input  logic              restart_i,
  input  logic              shift_i,
  input  logic              done_i,
  input  logic              allow_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int SW = WORD_W - 2;

  logic [SW-1:0]     shreg_q;
  logic [WORD_W-1:0] next_word;

  assign next_word = {shreg_q, pair_i.early, pair_i.late};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      shreg_q <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (restart_i) begin
        shreg_q <= SW'({pair_i.early, pair_i.late});
      end else if (shift_i) begin
        shreg_q <= next_word[SW-1:0];
        if (done_i) begin
          word_o  <= next_word;
          valid_o <= allow_i;
        end
      end
    end
  end

  p_valid_one_cycle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  p_word_held_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(done_i) |-> $stable(word_o));
endmodule

// File: rtl/sadc_deser.sv
module sadc_deser
  import sadc_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int LOCK_EDGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ser_i,
  input  logic              frame_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              locked_o
);
  localparam int PAIRS = WORD_W / 2;

  bit_pair_t pair_w;
  logic      edge_w;
  logic      restart_w;
  logic      shift_w;
  logic      done_w;
  logic      locked_w;

  sadc_ddr_capture u_capture (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .ser_i        (ser_i),
    .frame_i      (frame_i),
    .pair_o       (pair_w),
    .frame_edge_o (edge_w)
  );

  sadc_frame_tracker #(
    .PAIRS      (PAIRS),
    .LOCK_EDGES (LOCK_EDGES)
  ) u_tracker (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .edge_i    (edge_w),
    .restart_o (restart_w),
    .shift_o   (shift_w),
    .done_o    (done_w),
    .locked_o  (locked_w)
  );

  sadc_word_assembler #(
    .WORD_W (WORD_W)
  ) u_assembler (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pair_i    (pair_w),
    .restart_i (restart_w),
    .shift_i   (shift_w),
    .done_i    (done_w),
    .allow_i   (locked_w),
    .word_o    (word_o),
    .valid_o   (valid_o)
  );

  assign locked_o = locked_w;

  p_valid_only_locked_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> locked_o);

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!valid_o && !locked_o));
endmodule

// File: tb/sadc_deser_bench.sv
module sadc_deser_bench;
  localparam int W = 12;
  localparam int P = W / 2;

  logic         clk = 1'b0;
  logic         rst;
  logic         ser;
  logic         frame;
  logic [W-1:0] word;
  logic         valid;
  logic         locked;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  int exp_w [0:8191];
  int exp_due [0:8191];
  int head = 0;
  int tail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sadc_deser #(.WORD_W(W), .LOCK_EDGES(3)) u_sadc_deser (
    .clk_i    (clk),
    .rst_i    (rst),
    .ser_i    (ser),
    .frame_i  (frame),
    .word_o   (word),
    .valid_o  (valid),
    .locked_o (locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Output monitor, away from the rising edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (head != tail && exp_due[head] == cyc) begin
        chk(valid == 1'b1, "R4 valid at due cycle", int'(valid), 1);
        if (valid) chk(int'(word) == exp_w[head], "R2/R3 word value", int'(word), exp_w[head]);
        head++;
      end else if (valid) begin
        chk(1'b0, "R8/R9 unexpected valid", 1, 0);
      end
    end
  end

  task automatic send_word(input int v, input int n, input bit framed,
                           input bit exp_lock, input bit exp_valid, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      ser   = v[W-1-2*i];
      frame = framed && (i < n / 2);
      @(posedge clk); #2;
      ser = v[W-2-2*i];
      if (i == 1) chk(locked == exp_lock, tag, int'(locked), int'(exp_lock));
      if (i == n - 1 && n == P && exp_valid) begin
        exp_w[tail]   = v;
        exp_due[tail] = cyc + 1;
        tail++;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ser = 1'b0;
    frame = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    chk(word == '0, "R1 word in reset", int'(word), 0);
    chk(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    chk(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(valid == 1'b0, "R1 valid idle", int'(valid), 0);
    chk(locked == 1'b0, "R1 locked idle", int'(locked), 0);

    // Full sweep of sample values; words 0..2 build lock (R5, R8).
    for (int j = 0; j < 4099; j++)
      send_word((j * 1237) % 4096, P, 1'b1, j >= 3, j >= 3, "R5 lock state");

    // Early edge after four pairs (R6).
    send_word(12'hA5A, 4, 1'b1, 1'b1, 1'b0, "R5 lock held");
    for (int k = 0; k < 6; k++)
      send_word((k * 611 + 19) % 4096, P, 1'b1, k >= 3, k >= 3, "R6 realign after 4 pairs");

    // Early edge after five pairs, one short of a word (R6).
    send_word(12'h3C3, 5, 1'b1, 1'b1, 1'b0, "R5 lock held");
    for (int k = 0; k < 6; k++)
      send_word((k * 2749 + 7) % 4096, P, 1'b1, k >= 3, k >= 3, "R6 realign after 5 pairs");

    // Missing edge: bits ignored, then resync (R7, R8).
    send_word(12'h777, P, 1'b0, 1'b0, 1'b0, "R7 missing edge unlocks");
    for (int m = 0; m < 6; m++)
      send_word((m * 3001 + 1000) % 4096, P, 1'b1, m >= 3, m >= 3, "R7 resync");

    @(negedge clk); #2;
    frame = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    chk(head == tail, "R4 every expected word seen", tail - head, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule